// File: doc/BRIEF.md
# PCM Channel Rate and Format Sequencer

This block is the control path for a pair of sample channels in an audio engine. An engine tick, already divided down from the input clock, feeds a shared base divider. Every `BASE_DIV` ticks the divider fires a sample step. On each step every running channel counts down its own sub-divider. The sub-divider value depends on the channel's rate field and on whether the channel carries linear PCM or ADPCM.

When a channel's sub-divider expires in playback, the channel pulls the nibbles of one sample from its external FIFO. Linear samples are then aligned to 12 bits. An ADPCM nibble is instead handed to an external decoder, and the decoder's 12-bit result is taken back. When a channel's sub-divider expires in record mode, the channel pushes one silent sample of the selected width into its FIFO. A push into a full FIFO sets a sticky overflow flag.

After every step the held channel values are summed into a left and a right output according to the pan bits, and a one-cycle valid pulse marks the stereo pair.

Top module: `pcm_rate_fmt_seq`

## Requirements
- R1: One stereo pair (`smp_vld_o` high for one cycle) is produced per `BASE_DIV` (default 12) cycles with `tick_en_i` high. When `tick_en_i` is low, no pair is produced.
- R2: A channel advances only when its start bit (ctrl bit 0) is 1 and its reset bit (ctrl bit 7) is 0. Otherwise it makes no FIFO traffic and adds nothing to the sums.
- R3: The sub-divider is taken from {1,2,4,6,8}, indexed by the rate field (ctrl bits 4:3). When ctrl bit 2 is 0 (ADPCM), the index is increased by one. The counter reloads each time it expires, and it expires on the first step after a reset release.
- R4: Format field code 0 fetches 2 nibbles, code 1 fetches 3, code 2 fetches 4 and code 3 fetches 1. ADPCM always uses 1 nibble. The first nibble fetched is the most significant.
- R5: Linear samples are aligned to 12 bits and sign-extended to 16 bits. A 4-bit sample is shifted left by 8, an 8-bit sample is shifted left by 4, a 12-bit sample is kept as is, and a 16-bit sample drops its low nibble.
- R6: In playback a fetch stops early when the FIFO runs empty. The nibbles already taken form the sample, right-aligned.
- R7: In playback (ctrl bit 1 = 1), a running channel's value is added to the left sum when ctrl bit 5 is set and to the right sum when ctrl bit 6 is set. Channel 0 is added first, then channel 1, with 16-bit wraparound.
- R8: In record mode a channel pushes zero nibbles of the selected width and adds nothing to the sums. A push while `wr_full_i` is high sets `ovf_o`, which stays set until `rst_n`.
- R9: A 1-to-0 change of the reset bit raises `flush_o` for one cycle. It also reloads the sub-divider to 1 and clears the held output.
- R10: In ADPCM playback the nibble is offered on `adp_nib_o` with `adp_req_o` until `adp_ack_i` arrives. The 12-bit `adp_val_i` is then sign-extended and becomes the channel value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick_en_i | input | 1 | Engine tick enable |
| ctrl_i | input | NCH*8 | Per-channel control byte |
| fmt_i | input | NCH*2 | Per-channel sample-width code |
| rd_vld_i | input | NCH | FIFO holds a nibble |
| rd_nib_i | input | NCH*4 | FIFO head nibble |
| rd_pop_o | output | NCH | Take head nibble |
| wr_push_o | output | NCH | Push a record nibble |
| wr_nib_o | output | NCH*4 | Record nibble (always zero) |
| wr_full_i | input | NCH | FIFO full |
| flush_o | output | NCH | Empty FIFO and clear decoder state |
| adp_req_o | output | NCH | Decoder request |
| adp_nib_o | output | NCH*4 | Nibble to decode |
| adp_ack_i | input | NCH | Decoder result ready |
| adp_val_i | input | NCH*12 | Decoded 12-bit value |
| left_o | output | 16 | Left sum |
| right_o | output | 16 | Right sum |
| smp_vld_o | output | 1 | Stereo pair valid |
| ovf_o | output | 1 | Sticky record overflow |

## Verification
The hardest state to reach from the ports is a sub-divider caught part-way through its count at the moment the reset bit is released. The stimulus records with the slowest linear rate for three steps, which leaves the counter mid-count. It then toggles the reset bit and shows that the very next step pushes a sample. Rate checks count record pushes over twelve steps with `tick_en_i` gated by the bench, so that the step count is exact. Early FIFO exhaustion is reached by loading fewer nibbles than the width code asks for.

// File: rtl/pcmseq_pkg.sv
`timescale 1ns/1ps
package pcmseq_pkg;
   localparam int NIB_W = 4;
   localparam int ADP_W = 12;
   localparam int OUT_W = 16;
   localparam int CTL_W = 8;
   localparam int B_START = 0;
   localparam int B_PLAY  = 1;
   localparam int B_LIN   = 2;
   localparam int B_RATE  = 3;
   localparam int B_PANL  = 5;
   localparam int B_PANR  = 6;
   localparam int B_RST   = 7;

   typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_DECODE} seq_st_e;

   function automatic logic [2:0] nib_count(input logic [1:0] code, input logic lin);
      if (!lin) return 3'd1;
      case (code)
         2'd0: return 3'd2;
         2'd1: return 3'd3;
         2'd2: return 3'd4;
         default: return 3'd1;
      endcase
   endfunction

   function automatic logic [3:0] rate_div(input logic [1:0] rate, input logic lin);
      logic [2:0] idx;
      idx = {1'b0, rate} + {2'b00, ~lin};
      case (idx)
         3'd0: return 4'd1;
         3'd1: return 4'd2;
         3'd2: return 4'd4;
         3'd3: return 4'd6;
         default: return 4'd8;
      endcase
   endfunction

   function automatic logic [OUT_W-1:0] align12(input logic [15:0] raw, input logic [2:0] n);
      logic [ADP_W-1:0] a;
      case (n)
         3'd1: a = {raw[3:0], 8'h00};
         3'd2: a = {raw[7:0], 4'h0};
         3'd3: a = raw[11:0];
         default: a = raw[15:4];
      endcase
      return {{(OUT_W-ADP_W){a[ADP_W-1]}}, a};
   endfunction
endpackage

// File: rtl/pcmseq_basediv.sv
`timescale 1ns/1ps
module pcmseq_basediv #(
   parameter int BASE_DIV = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   output logic step_o
);
   localparam int CW = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;

   if (BASE_DIV < 1) begin : g_bad_div
      $error("BASE_DIV must be at least 1");
   end

   if (BASE_DIV == 1) begin : g_pass
      assign step_o = tick_i;
   end else begin : g_count
      logic [CW-1:0] cnt;
      assign step_o = tick_i && (cnt == CW'(BASE_DIV - 1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      cnt <= '0;
         else if (step_o) cnt <= '0;
         else if (tick_i) cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/pcmseq_chan.sv
`timescale 1ns/1ps
module pcmseq_chan
   import pcmseq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_i,
   input  logic             start_i,
   input  logic             hold_i,
   input  logic             play_i,
   input  logic             lin_i,
   input  logic [1:0]       rate_i,
   input  logic [1:0]       fmt_i,
   input  logic             rd_vld_i,
   input  logic [NIB_W-1:0] rd_nib_i,
   output logic             rd_pop_o,
   output logic             wr_push_o,
   output logic [NIB_W-1:0] wr_nib_o,
   input  logic             wr_full_i,
   output logic             flush_o,
   output logic             adp_req_o,
   output logic [NIB_W-1:0] adp_nib_o,
   input  logic             adp_ack_i,
   input  logic [ADP_W-1:0] adp_val_i,
   output logic             run_o,
   output logic             idle_o,
   output logic             ovf_hit_o,
   output logic [OUT_W-1:0] sample_o
);
   seq_st_e          state;
   logic             hold_q;
   logic [3:0]       sub_cnt;
   logic [2:0]       rem;
   logic [15:0]      raw;
   logic [OUT_W-1:0] out_q;
   logic             fetch_done;

   assign run_o      = start_i & ~hold_i;
   assign flush_o    = hold_q & ~hold_i;
   assign idle_o     = (state == ST_IDLE);
   assign rd_pop_o   = (state == ST_FETCH) && play_i && (rem != 3'd0) && rd_vld_i;
   assign wr_push_o  = (state == ST_FETCH) && !play_i && (rem != 3'd0);
   assign wr_nib_o   = '0;
   assign ovf_hit_o  = wr_push_o & wr_full_i;
   assign adp_req_o  = (state == ST_DECODE);
   assign adp_nib_o  = raw[NIB_W-1:0];
   assign sample_o   = out_q;
   assign fetch_done = (rem == 3'd0) || !rd_vld_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         hold_q  <= 1'b1;
         sub_cnt <= 4'd1;
         rem     <= '0;
         raw     <= '0;
         out_q   <= '0;
      end else begin
         hold_q <= hold_i;
         if (flush_o) begin
            state   <= ST_IDLE;
            sub_cnt <= 4'd1;
            out_q   <= '0;
            raw     <= '0;
            rem     <= '0;
         end else begin
            case (state)
               ST_IDLE: if (step_i && run_o) begin
                  if (sub_cnt == 4'd1) begin
                     sub_cnt <= rate_div(rate_i, lin_i);
                     rem     <= nib_count(fmt_i, lin_i);
                     raw     <= '0;
                     state   <= ST_FETCH;
                  end else begin
                     sub_cnt <= sub_cnt - 4'd1;
                  end
               end
               ST_FETCH: if (!play_i) begin
                  if (rem == 3'd0) state <= ST_IDLE;
                  else             rem <= rem - 3'd1;
               end else if (fetch_done) begin
                  if (lin_i) begin
                     out_q <= align12(raw, nib_count(fmt_i, lin_i));
                     state <= ST_IDLE;
                  end else begin
                     state <= ST_DECODE;
                  end
               end else begin
                  raw <= {raw[11:0], rd_nib_i};
                  rem <= rem - 3'd1;
               end
               ST_DECODE: if (adp_ack_i) begin
                  out_q <= {{(OUT_W-ADP_W){adp_val_i[ADP_W-1]}}, adp_val_i};
                  state <= ST_IDLE;
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   // R2
   halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_o && !run_o) |=> idle_o);
   // R9
   flush_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_o |=> (sub_cnt == 4'd1 && idle_o && out_q == '0));
   // R3
   div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sub_cnt != 4'd0 && sub_cnt <= 4'd8));
   // R1
   step_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step_i |-> idle_o);
endmodule

// File: rtl/pcm_rate_fmt_seq.sv
`timescale 1ns/1ps
module pcm_rate_fmt_seq
   import pcmseq_pkg::*;
#(
   parameter int NCH      = 2,
   parameter int BASE_DIV = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick_en_i,
   input  logic [NCH*CTL_W-1:0] ctrl_i,
   input  logic [NCH*2-1:0]     fmt_i,
   input  logic [NCH-1:0]       rd_vld_i,
   input  logic [NCH*NIB_W-1:0] rd_nib_i,
   output logic [NCH-1:0]       rd_pop_o,
   output logic [NCH-1:0]       wr_push_o,
   output logic [NCH*NIB_W-1:0] wr_nib_o,
   input  logic [NCH-1:0]       wr_full_i,
   output logic [NCH-1:0]       flush_o,
   output logic [NCH-1:0]       adp_req_o,
   output logic [NCH*NIB_W-1:0] adp_nib_o,
   input  logic [NCH-1:0]       adp_ack_i,
   input  logic [NCH*ADP_W-1:0] adp_val_i,
   output logic [OUT_W-1:0]     left_o,
   output logic [OUT_W-1:0]     right_o,
   output logic                 smp_vld_o,
   output logic                 ovf_o
);
   if (NCH < 1) begin : g_bad_nch
      $error("NCH must be at least 1");
   end

   logic             step;
   logic [NCH-1:0]   run, idle, ovf_hit;
   logic [OUT_W-1:0] samp [NCH];
   logic [OUT_W-1:0] sum_l, sum_r;
   logic             pend;
   logic             all_idle;

   pcmseq_basediv #(.BASE_DIV(BASE_DIV)) u_div (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_en_i), .step_o(step)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      pcmseq_chan u_ch (
         .clk(clk), .rst_n(rst_n), .step_i(step),
         .start_i(ctrl_i[c*CTL_W+B_START]), .hold_i(ctrl_i[c*CTL_W+B_RST]),
         .play_i(ctrl_i[c*CTL_W+B_PLAY]), .lin_i(ctrl_i[c*CTL_W+B_LIN]),
         .rate_i(ctrl_i[c*CTL_W+B_RATE +: 2]), .fmt_i(fmt_i[c*2 +: 2]),
         .rd_vld_i(rd_vld_i[c]), .rd_nib_i(rd_nib_i[c*NIB_W +: NIB_W]),
         .rd_pop_o(rd_pop_o[c]), .wr_push_o(wr_push_o[c]),
         .wr_nib_o(wr_nib_o[c*NIB_W +: NIB_W]), .wr_full_i(wr_full_i[c]),
         .flush_o(flush_o[c]), .adp_req_o(adp_req_o[c]),
         .adp_nib_o(adp_nib_o[c*NIB_W +: NIB_W]), .adp_ack_i(adp_ack_i[c]),
         .adp_val_i(adp_val_i[c*ADP_W +: ADP_W]), .run_o(run[c]),
         .idle_o(idle[c]), .ovf_hit_o(ovf_hit[c]), .sample_o(samp[c])
      );
   end

   assign all_idle = &idle;

   always_comb begin
      sum_l = '0;
      sum_r = '0;
      for (int c = 0; c < NCH; c++) begin
         if (run[c] && ctrl_i[c*CTL_W+B_PLAY]) begin
            if (ctrl_i[c*CTL_W+B_PANL]) sum_l = sum_l + samp[c];
            if (ctrl_i[c*CTL_W+B_PANR]) sum_r = sum_r + samp[c];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend      <= 1'b0;
         smp_vld_o <= 1'b0;
         left_o    <= '0;
         right_o   <= '0;
         ovf_o     <= 1'b0;
      end else begin
         smp_vld_o <= 1'b0;
         ovf_o     <= ovf_o | (|ovf_hit);
         if (step) begin
            pend <= 1'b1;
         end else if (pend && all_idle) begin
            pend      <= 1'b0;
            smp_vld_o <= 1'b1;
            left_o    <= sum_l;
            right_o   <= sum_r;
         end
      end
   end

   // R8
   ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_o) |-> $past(|ovf_hit));
   // R1
   pair_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smp_vld_o |-> $past(all_idle && pend));
endmodule

// File: tb/sim_pcm_rate_fmt_seq.sv
`timescale 1ns/1ps
module sim_pcm_rate_fmt_seq;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_en = 1'b0;
   logic [15:0] ctrl = 16'h8080;
   logic [3:0]  fmt = 4'h0;
   logic [1:0]  wr_full = 2'b00;
   logic [1:0]  rd_vld;
   logic [7:0]  rd_nib;
   logic [1:0]  rd_pop, wr_push, flush, adp_req;
   logic [7:0]  wr_nib, adp_nib;
   logic [1:0]  adp_ack = 2'b00;
   logic [23:0] adp_val = '0;
   logic [15:0] left, right;
   logic        smp_vld, ovf;

   logic [3:0] fq [2][64];
   logic [5:0] wp [2] = '{6'd0, 6'd0};
   logic [5:0] rp [2] = '{6'd0, 6'd0};
   int push_cnt [2] = '{0, 0};
   int nz_cnt = 0;
   int n_chk = 0, n_bad = 0;

   always #2 clk = ~clk;

   pcm_rate_fmt_seq u0 (
      .clk(clk), .rst_n(rst_n), .tick_en_i(tick_en), .ctrl_i(ctrl), .fmt_i(fmt),
      .rd_vld_i(rd_vld), .rd_nib_i(rd_nib), .rd_pop_o(rd_pop), .wr_push_o(wr_push),
      .wr_nib_o(wr_nib), .wr_full_i(wr_full), .flush_o(flush), .adp_req_o(adp_req),
      .adp_nib_o(adp_nib), .adp_ack_i(adp_ack), .adp_val_i(adp_val),
      .left_o(left), .right_o(right), .smp_vld_o(smp_vld), .ovf_o(ovf)
   );

   for (genvar c = 0; c < 2; c++) begin : g_fifo
      assign rd_vld[c] = (wp[c] != rp[c]);
      assign rd_nib[c*4 +: 4] = fq[c][rp[c]];
   end

   always @(posedge clk) begin
      for (int c = 0; c < 2; c++) begin
         if (flush[c])       rp[c] <= wp[c];
         else if (rd_pop[c]) rp[c] <= rp[c] + 6'd1;
         if (wr_push[c]) push_cnt[c] <= push_cnt[c] + 1;
         if (wr_push[c] && wr_nib[c*4 +: 4] != 4'h0) nz_cnt <= nz_cnt + 1;
         adp_ack[c] <= adp_req[c] & ~adp_ack[c];
         adp_val[c*12 +: 12] <= {3{adp_nib[c*4 +: 4]}};
      end
   end

   function automatic logic [7:0] ctl(input logic st, pl, lin, input logic [1:0] rt,
                                      input logic l, r, rs);
      return {rs, r, l, rt, lin, pl, st};
   endfunction

   task automatic chk(input string req, input logic [31:0] got, exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic push_nibs(input int c, input logic [15:0] d, input int n);
      for (int i = n - 1; i >= 0; i--) begin
         fq[c][wp[c]] = d[i*4 +: 4];
         wp[c] = wp[c] + 6'd1;
      end
   endtask

   task automatic restart(input int c, input logic [7:0] v, input logic [1:0] f);
      @(negedge clk);
      ctrl[c*8 +: 8] = 8'h80;
      fmt[c*2 +: 2] = f;
      repeat (2) @(negedge clk);
      ctrl[c*8 +: 8] = v;
      repeat (2) @(negedge clk);
   endtask

   task automatic wait_vld(input string req);
      int t = 0;
      do begin @(negedge clk); t++; end while (!smp_vld && t < 200);
      if (!smp_vld) chk({req, " timeout"}, 32'd0, 32'd1);
   endtask

   task automatic run_steps(input int k);
      tick_en = 1'b1;
      for (int i = 0; i < k; i++) wait_vld("R1");
      tick_en = 1'b0;
   endtask

   task automatic rate_case(input logic lin, input logic [1:0] rt, input logic [1:0] f,
                            input int exp, input string req);
      int p0;
      restart(0, ctl(1, 0, lin, rt, 1, 0, 0), f);
      p0 = push_cnt[0];
      run_steps(12);
      chk(req, push_cnt[0] - p0, exp);
   endtask

   // {width code, sample data, expected 16-bit output}
   localparam logic [33:0] VEC [9] = '{
      {2'd3, 16'h0007, 16'h0700}, {2'd3, 16'h0008, 16'hF800},
      {2'd0, 16'h007F, 16'h07F0}, {2'd0, 16'h0081, 16'hF810},
      {2'd1, 16'h0ABC, 16'hFABC}, {2'd1, 16'h0123, 16'h0123},
      {2'd2, 16'h1234, 16'h0123}, {2'd2, 16'h8765, 16'hF876},
      {2'd2, 16'h7FFF, 16'h07FF}
   };

   initial begin
      #400000;
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int p0, n;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset vld", smp_vld, 0);
      chk("R1 reset sums", {left, right}, 0);
      chk("R8 reset ovf", ovf, 0);
      chk("R2 reset traffic", {rd_pop, wr_push}, 0);

      // R1: pair period and gating
      tick_en = 1'b1;
      wait_vld("R1");
      n = 0;
      do begin @(negedge clk); n++; end while (!smp_vld && n < 100);
      chk("R1 period", n, 12);
      tick_en = 1'b0;
      n = 0;
      repeat (40) begin @(negedge clk); if (smp_vld) n++; end
      chk("R1 no tick no pair", n, 0);

      // R4 / R5: width codes and alignment
      for (int i = 0; i < 9; i++) begin
         logic [2:0] nn;
         nn = (VEC[i][33:32] == 2'd3) ? 3'd1 : 3'(VEC[i][33:32] + 2);
         restart(0, ctl(1, 1, 1, 0, 1, 0, 0), VEC[i][33:32]);
         push_nibs(0, VEC[i][31:16], int'(nn));
         run_steps(1);
         chk($sformatf("R5 R4 vector %0d", i), left, {16'h0, VEC[i][15:0]});
      end

      // R6: FIFO runs dry part-way
      restart(0, ctl(1, 1, 1, 0, 1, 0, 0), 2'd0);
      push_nibs(0, 16'h0007, 1);
      run_steps(1);
      chk("R6 partial sample", left, 16'h0070);
      chk("R6 fifo drained", rd_vld[0], 0);

      // R7: pan and summing
      restart(0, ctl(1, 1, 1, 0, 0, 1, 0), 2'd0);
      push_nibs(0, 16'h0040, 2);
      run_steps(1);
      chk("R7 right only", {left, right}, {16'h0000, 16'h0400});
      restart(0, ctl(1, 1, 1, 0, 1, 1, 0), 2'd0);
      restart(1, ctl(1, 1, 1, 0, 1, 0, 0), 2'd0);
      push_nibs(0, 16'h0040, 2);
      push_nibs(1, 16'h0020, 2);
      run_steps(1);
      chk("R7 two channel sum", {left, right}, {16'h0600, 16'h0400});
      restart(0, ctl(1, 1, 1, 0, 1, 0, 0), 2'd0);
      restart(1, ctl(1, 1, 1, 0, 1, 0, 0), 2'd0);
      push_nibs(0, 16'h0080, 2);
      push_nibs(1, 16'h0080, 2);
      run_steps(1);
      chk("R7 wraparound", left, 16'hF000);
      ctrl[15:8] = 8'h80;

      // R2: not started, then held in reset
      restart(0, ctl(0, 1, 1, 0, 1, 0, 0), 2'd0);
      push_nibs(0, 16'h0055, 2);
      run_steps(2);
      chk("R2 no start output", left, 0);
      chk("R2 no start fifo", 6'(wp[0] - rp[0]), 2);
      @(negedge clk);
      ctrl[7:0] = ctl(1, 1, 1, 0, 1, 0, 1);
      run_steps(2);
      chk("R2 held reset output", left, 0);
      chk("R2 held reset fifo", 6'(wp[0] - rp[0]), 2);

      // R8: record mode
      restart(0, ctl(1, 0, 1, 0, 1, 0, 0), 2'd1);
      p0 = push_cnt[0];
      run_steps(1);
      chk("R8 record pushes", push_cnt[0] - p0, 3);
      chk("R8 zero data", nz_cnt, 0);
      chk("R8 no output", left, 0);
      chk("R8 no ovf yet", ovf, 0);
      wr_full[0] = 1'b1;
      run_steps(1);
      wr_full[0] = 1'b0;
      chk("R8 ovf set", ovf, 1);
      run_steps(1);
      chk("R8 ovf sticky", ovf, 1);

      // R3: sub-divider table
      rate_case(1, 2'd0, 2'd3, 12, "R3 lin rate0");
      rate_case(1, 2'd1, 2'd3, 6,  "R3 lin rate1");
      rate_case(1, 2'd2, 2'd3, 3,  "R3 lin rate2");
      rate_case(1, 2'd3, 2'd3, 2,  "R3 lin rate3");
      rate_case(0, 2'd0, 2'd0, 6,  "R3 R4 adpcm rate0");
      rate_case(0, 2'd1, 2'd0, 3,  "R3 adpcm rate1");
      rate_case(0, 2'd3, 2'd0, 2,  "R3 adpcm rate3");

      // R9: reset release reloads mid-count divider and flushes
      restart(0, ctl(1, 0, 1, 2'd3, 0, 0, 0), 2'd3);
      run_steps(3);
      push_nibs(0, 16'h0123, 3);
      restart(0, ctl(1, 0, 1, 2'd3, 0, 0, 0), 2'd3);
      chk("R9 fifo flushed", 6'(wp[0] - rp[0]), 0);
      p0 = push_cnt[0];
      run_steps(1);
      chk("R9 counter reloaded", push_cnt[0] - p0, 1);

      // R10: ADPCM playback through decoder
      restart(0, ctl(1, 1, 0, 0, 1, 0, 0), 2'd2);
      push_nibs(0, 16'h00A3, 2);
      run_steps(1);
      chk("R10 decoded value", left, 16'hFAAA);
      chk("R10 R4 one nibble", 6'(wp[0] - rp[0]), 1);
      run_steps(1);
      chk("R10 held between fetches", left, 16'hFAAA);
      run_steps(1);
      chk("R10 next decode", left, 16'h0333);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule